// File: doc/BRIEF.md
# Two-Dimensional 8x8 Cosine Transform with Shared Transpose Buffer

This block turns a stream of 8x8 blocks of signed samples into their two-dimensional discrete cosine transform. A first one-dimensional transform engine works on each row of the incoming block. Its results go into a 64-word transpose memory. A second engine reads that memory down the columns and produces the final coefficients. Both engines are sequential multiply-accumulate units behind a valid/ready sample stream. Each one takes eight samples and then returns eight coefficients, spending eight multiply cycles plus one hand-over cycle on each coefficient.

Only one transpose memory exists, and it is read and written in the same cycle. While the column side drains block b, the row side already fills block b+1. Each new element goes into the slot the reader has just freed. So the write addressing flips between row order and column order from block to block, and the read side always uses the opposite order. A controller runs two small state machines:

- The writer has the states WR_FILL and WR_HOLD. It goes from WR_FILL to WR_HOLD on the 64th write. It goes from WR_HOLD back to WR_FILL at hand-over.
- The reader has the states RD_IDLE and RD_DRAIN. It goes from RD_IDLE to RD_DRAIN at hand-over. It goes from RD_DRAIN back to RD_IDLE on the 64th read issue.
- Hand-over happens when the writer is in WR_HOLD and the reader is in RD_IDLE. At that moment the writer's order toggles.
- Each engine has the states EN_LOAD, EN_MAC and EN_EMIT:
  - EN_LOAD to EN_MAC after the 8th accepted sample.
  - EN_MAC to EN_EMIT after the 8th product.
  - EN_EMIT to EN_MAC when a coefficient that is not the last is accepted.
  - EN_EMIT to EN_LOAD when the last coefficient is accepted.

Backpressure from the output travels back through the column engine, the buffer slots and the row engine to `in_ready`.

Top module: `dct2d_xpose`

## Requirements
- R1: After reset, `out_valid` and `block_done` are 0 and `in_ready` is 1.
- R2: Input samples are 12-bit two's complement. A sample is taken on a clock edge where `in_valid` and `in_ready` are both 1. The samples of a block arrive row by row: sample i of the block is element (row i/8, column i%8).
- R3: Each stage computes Z[k] = floor((sum over n of C(k,n)*x[n] + 2048) / 4096), with C(0,n) = 1448 and C(k,n) = round(2048*cos((2n+1)k*pi/16)) for k>0. The row stage gives T[r][k] from input row r. The column stage gives Y[u][k] from column k of T.
- R4: Output j of a block (0..63) is Y[j%8][j/8]. The result is a 16-bit two's complement value and appears on a clock edge where `out_valid` and `out_ready` are both 1.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R6: While `out_ready` is held at 0, `in_ready` goes low and stays low, and fewer than 192 samples are taken after the stall begins.
- R7: `block_done` is 1 for exactly the one cycle after the edge that takes the 64th output of a block, and is 0 at all other times.
- R8: Back-to-back blocks, including input gaps and random output stalls, give correct results as the buffer order alternates. The transpose memory is never written and read at the same address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts an input sample |
| in_data | input | IN_W (12) | Signed input sample, row-major within the block |
| out_valid | output | 1 | Output coefficient present |
| out_ready | input | 1 | Downstream accepts the coefficient |
| out_data | output | DATA_W (16) | Signed coefficient, column-major within the block |
| block_done | output | 1 | One-cycle pulse after a block's last coefficient is taken |

## Verification
The checks on output holding and on the done pulse assume that the environment keeps `in_valid` and `in_data` steady until a sample is taken. The bench drives inputs only at falling edges and changes them only after a handshake.

The transform arithmetic assumes that inputs stay within 12 bits, so that the 16-bit intermediates never overflow. The stimulus respects this bound: the extremes are ±2047 and -2048, and the random patterns are masked to 12 bits.

The stimulus reaches the alternating buffer orders through an impulse sweep over all 64 positions, followed by streams of many back-to-back blocks.

// File: rtl/dct2d_pkg.sv
package dct2d_pkg;

    localparam int PTS    = 8;
    localparam int IDX_W  = $clog2(PTS);
    localparam int COEF_W = 13;
    localparam int FRAC_W = 12;

    typedef enum logic [1:0] {
        EN_LOAD,
        EN_MAC,
        EN_EMIT
    } eng_state_e;

    typedef enum logic {
        WR_FILL,
        WR_HOLD
    } wr_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_DRAIN
    } rd_state_e;

    // Scaled cosine weight for frequency k and sample n (8-point transform).
    function automatic logic signed [COEF_W-1:0] cos_coef(
        input logic [IDX_W-1:0] k,
        input logic [IDX_W-1:0] n
    );
        int  m;
        int  mag;
        logic neg;
        m   = ((2 * int'(n) + 1) * int'(k)) % 32;
        neg = 1'b0;
        if (m > 16) m = 32 - m;
        if (m > 8) begin
            m   = 16 - m;
            neg = 1'b1;
        end
        case (m)
            0:       mag = 2048;
            1:       mag = 2009;
            2:       mag = 1892;
            3:       mag = 1703;
            4:       mag = 1448;
            5:       mag = 1138;
            6:       mag = 784;
            7:       mag = 400;
            default: mag = 0;
        endcase
        if (k == '0) begin
            mag = 1448;
            neg = 1'b0;
        end
        return neg ? COEF_W'(-mag) : COEF_W'(mag);
    endfunction

endpackage

// File: rtl/dct1d_mac_engine.sv
module dct1d_mac_engine
    import dct2d_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + IDX_W;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PTS - 1);

    eng_state_e state_q, state_d;

    logic signed [DATA_W-1:0] samp_q [PTS];
    logic        [IDX_W-1:0]  n_q;
    logic        [IDX_W-1:0]  k_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [DATA_W-1:0] res_q;

    logic                     last_n;
    logic                     last_k;
    logic signed [COEF_W-1:0] coef;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_sum;
    logic signed [ACC_W-1:0]  acc_rnd;
    logic signed [ACC_W-1:0]  acc_shf;

    assign last_n  = (n_q == LAST_IDX);
    assign last_k  = (k_q == LAST_IDX);
    assign coef    = cos_coef(k_q, n_q);
    assign prod    = samp_q[n_q] * coef;
    assign acc_sum = acc_q + ACC_W'(prod);
    assign acc_rnd = acc_sum + HALF;
    assign acc_shf = acc_rnd >>> FRAC_W;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EN_LOAD;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_LOAD: if (in_valid && last_n) state_d = EN_MAC;
            EN_MAC:  if (last_n)             state_d = EN_EMIT;
            EN_EMIT: if (out_ready)          state_d = last_k ? EN_LOAD : EN_MAC;
            default:                         state_d = EN_LOAD;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PTS; i++) samp_q[i] <= '0;
            n_q   <= '0;
            k_q   <= '0;
            acc_q <= '0;
            res_q <= '0;
        end else begin
            unique case (state_q)
                EN_LOAD: begin
                    k_q   <= '0;
                    acc_q <= '0;
                    if (in_valid) begin
                        samp_q[n_q] <= in_data;
                        n_q         <= last_n ? '0 : n_q + 1'b1;
                    end
                end
                EN_MAC: begin
                    if (last_n) begin
                        res_q <= DATA_W'(acc_shf);
                        n_q   <= '0;
                    end else begin
                        acc_q <= acc_sum;
                        n_q   <= n_q + 1'b1;
                    end
                end
                EN_EMIT: begin
                    if (out_ready) begin
                        acc_q <= '0;
                        n_q   <= '0;
                        k_q   <= last_k ? '0 : k_q + 1'b1;
                    end
                end
                default: n_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state_q == EN_LOAD);
        out_valid = (state_q == EN_EMIT);
        out_data  = res_q;
    end

endmodule

// File: rtl/xpose_ram.sv
module xpose_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data      <= mem[rd_addr];
    end

endmodule

// File: rtl/xpose_ctrl.sv
module xpose_ctrl
    import dct2d_pkg::*;
#(
    parameter int ADDR_W = 2 * IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    output logic              wr_grant,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_take,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rq_valid
);

    localparam int CNT_W = ADDR_W + 1;
    localparam int HALF_W = ADDR_W / 2;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'((1 << ADDR_W) - 1);

    wr_state_e wr_st_q, wr_st_d;
    rd_state_e rd_st_q, rd_st_d;

    logic [CNT_W-1:0]  wr_cnt_q, rd_cnt_q;
    logic              wr_mode_q, rd_mode_q;
    logic              rq_valid_q;
    logic              handoff;
    logic              slot_free;
    logic              wr_last, rd_last;
    logic [ADDR_W-1:0] wj, rj;

    assign handoff   = (wr_st_q == WR_HOLD) && (rd_st_q == RD_IDLE);
    assign slot_free = (rd_st_q == RD_IDLE) || (wr_cnt_q < rd_cnt_q);
    assign wr_last   = (wr_cnt_q == LAST_SLOT);
    assign rd_last   = (rd_cnt_q == LAST_SLOT);
    assign wj        = wr_cnt_q[ADDR_W-1:0];
    assign rj        = rd_cnt_q[ADDR_W-1:0];

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_st_q <= WR_FILL;
            rd_st_q <= RD_IDLE;
        end else begin
            wr_st_q <= wr_st_d;
            rd_st_q <= rd_st_d;
        end
    end

    // Writer transitions
    always_comb begin
        wr_st_d = wr_st_q;
        unique case (wr_st_q)
            WR_FILL: if (wr_en && wr_last) wr_st_d = WR_HOLD;
            WR_HOLD: if (handoff)          wr_st_d = WR_FILL;
            default:                       wr_st_d = WR_FILL;
        endcase
    end

    // Reader transitions
    always_comb begin
        rd_st_d = rd_st_q;
        unique case (rd_st_q)
            RD_IDLE:  if (handoff)         rd_st_d = RD_DRAIN;
            RD_DRAIN: if (rd_en && rd_last) rd_st_d = RD_IDLE;
            default:                        rd_st_d = RD_IDLE;
        endcase
    end

    // Counters, order bits, read-data valid
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt_q   <= '0;
            rd_cnt_q   <= '0;
            wr_mode_q  <= 1'b0;
            rd_mode_q  <= 1'b0;
            rq_valid_q <= 1'b0;
        end else begin
            if (handoff) begin
                wr_cnt_q  <= '0;
                wr_mode_q <= ~wr_mode_q;
                rd_cnt_q  <= '0;
                rd_mode_q <= wr_mode_q;
            end else begin
                if (wr_en) wr_cnt_q <= wr_cnt_q + 1'b1;
                if (rd_en) rd_cnt_q <= rd_cnt_q + 1'b1;
            end
            if (rd_en)        rq_valid_q <= 1'b1;
            else if (rd_take) rq_valid_q <= 1'b0;
        end
    end

    // Outputs: the writer and the reader always use opposite orders
    always_comb begin
        wr_grant = (wr_st_q == WR_FILL) && slot_free;
        wr_en    = wr_grant && wr_req;
        wr_addr  = wr_mode_q ? {wj[HALF_W-1:0], wj[ADDR_W-1:HALF_W]} : wj;
        rd_en    = (rd_st_q == RD_DRAIN) && (!rq_valid_q || rd_take);
        rd_addr  = rd_mode_q ? rj : {rj[HALF_W-1:0], rj[ADDR_W-1:HALF_W]};
        rq_valid = rq_valid_q;
    end

endmodule

// File: rtl/dct2d_xpose.sv
module dct2d_xpose
    import dct2d_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IN_W-1:0]   in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              block_done
);

    localparam int ADDR_W = 2 * IDX_W;

    logic signed [DATA_W-1:0] s1_in;
    logic                     s1_ov, s1_or;
    logic signed [DATA_W-1:0] s1_od;

    logic                     wr_en, rd_en, rq_valid, rd_take;
    logic [ADDR_W-1:0]        wr_addr, rd_addr;
    logic [DATA_W-1:0]        rd_data;

    logic                     s2_ir;
    logic signed [DATA_W-1:0] s2_od;

    logic [ADDR_W-1:0]        out_cnt_q;
    logic                     done_q;
    logic                     out_hs;

    assign s1_in   = {{(DATA_W - IN_W){in_data[IN_W-1]}}, in_data};
    assign rd_take = rq_valid && s2_ir;

    dct1d_mac_engine #(.DATA_W(DATA_W)) row_eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (s1_in),
        .out_valid (s1_ov),
        .out_ready (s1_or),
        .out_data  (s1_od)
    );

    xpose_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (s1_ov),
        .wr_grant (s1_or),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_take  (rd_take),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rq_valid (rq_valid)
    );

    xpose_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (s1_od),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    dct1d_mac_engine #(.DATA_W(DATA_W)) col_eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rq_valid),
        .in_ready  (s2_ir),
        .in_data   (rd_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (s2_od)
    );

    assign out_data = s2_od;
    assign out_hs   = out_valid && out_ready;

    // Output counter and end-of-block pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_cnt_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= out_hs && (out_cnt_q == '1);
            if (out_hs) out_cnt_q <= out_cnt_q + 1'b1;
        end
    end

    assign block_done = done_q;

endmodule

// File: rtl/dct2d_xpose_chk.sv
module dct2d_xpose_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              block_done,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr
);

    a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);

    a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_data));

    a_r7_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> $past(out_valid && out_ready));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done);

    a_r8_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en && (wr_addr == rd_addr)));

endmodule

bind dct2d_xpose dct2d_xpose_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .block_done (block_done),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr)
);

// File: tb/dct2d_xpose_tb_top.sv
module dct2d_xpose_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W       = 12;
    localparam int DATA_W     = 16;
    localparam int NBLK       = 75;
    localparam int MAIN_BLK   = 72;
    localparam int WATCHDOG   = 190000;

    logic              clk;
    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [IN_W-1:0]   in_data;
    logic              out_valid;
    logic              out_ready;
    logic [DATA_W-1:0] out_data;
    logic              block_done;

    int checks;
    int errors;
    int in_blk  [NBLK*64];
    int exp_blk [NBLK*64];
    int out_idx;
    int accepted;
    int cycles;
    bit force_stall;
    bit done_exp;
    bit stall_prev;
    logic [DATA_W-1:0] data_prev;
    int unsigned seed;

    dct2d_xpose #(.IN_W(IN_W), .DATA_W(DATA_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .block_done (block_done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int weight(input int k, input int n);
        if (k == 0) return 1448;
        return $rtoi($floor(2048.0 * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 16.0) + 0.5));
    endfunction

    function automatic int next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'((seed >> 12) & 32'hFFF);
    endfunction

    // Expected results for block b, from the transform formula
    function automatic void calc_block(input int b);
        int t [8][8];
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 8; k++) begin
                longint s = 0;
                for (int c = 0; c < 8; c++) s += longint'(weight(k, c)) * in_blk[b*64 + r*8 + c];
                t[r][k] = int'((s + 2048) >>> 12);
            end
        end
        for (int k = 0; k < 8; k++) begin
            for (int u = 0; u < 8; u++) begin
                longint s = 0;
                for (int r = 0; r < 8; r++) s += longint'(weight(u, r)) * t[r][k];
                exp_blk[b*64 + k*8 + u] = int'((s + 2048) >>> 12);
            end
        end
    endfunction

    function automatic void build_all();
        for (int b = 0; b < NBLK; b++) begin
            for (int i = 0; i < 64; i++) begin
                int v;
                if (b < 64)       v = (i == b) ? ((b % 2 == 0) ? 2047 : -2048) : 0;
                else if (b == 64) v = 2047;
                else if (b == 65) v = -2048;
                else if (b == 66) v = (((i / 8) + (i % 8)) % 2 == 0) ? 2047 : -2047;
                else if (b == 67) v = i * 60 - 1920;
                else              v = next_rand() - 2048;
                in_blk[b*64 + i] = v;
            end
            calc_block(b);
        end
    endfunction

    task automatic send_block(input int b, input bit gaps);
        for (int i = 0; i < 64; i++) begin
            in_data  = IN_W'(in_blk[b*64 + i]);
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            accepted++;
            in_valid = 1'b0;
            if (gaps && (next_rand() % 4 == 0)) repeat (next_rand() % 5) @(negedge clk);
        end
    endtask

    function automatic string tag_of(input int idx);
        int b = idx / 64;
        if (b < 64)       return "R2 R3 R4";
        if (b < 68)       return "R3 R4";
        if (b < MAIN_BLK) return "R5 R8";
        return "R6 R8";
    endfunction

    // Output side: stall control, data, hold and done-pulse checks
    always @(negedge clk) begin
        if (rst_n) begin
            if (block_done || done_exp)
                check(block_done == done_exp, "R7 block_done", int'(block_done), int'(done_exp));
            if (stall_prev) begin
                check(out_valid == 1'b1, "R5 valid held", int'(out_valid), 1);
                check(out_data == data_prev, "R5 data held", int'($signed(out_data)), int'($signed(data_prev)));
            end
            if (force_stall)
                out_ready = 1'b0;
            else if (out_idx / 64 >= 68 && out_idx / 64 < MAIN_BLK)
                out_ready = (next_rand() % 10) < 6;
            else
                out_ready = 1'b1;
            done_exp = 1'b0;
            if (out_valid && out_ready) begin
                if (out_idx < NBLK*64) begin
                    check($signed(out_data) == exp_blk[out_idx], tag_of(out_idx),
                          int'($signed(out_data)), exp_blk[out_idx]);
                end
                out_idx++;
                done_exp = (out_idx % 64 == 0);
            end
            stall_prev = out_valid && !out_ready;
            data_prev  = out_data;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d outputs expected %0d", out_idx, NBLK*64);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0; out_idx = 0; accepted = 0; cycles = 0;
        force_stall = 1'b0; done_exp = 1'b0; stall_prev = 1'b0; data_prev = '0;
        seed = 32'd12345;
        in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        rst_n = 1'b0;
        build_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(block_done == 1'b0, "R1 block_done", int'(block_done), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // Impulse sweep, extremes, patterns, then gapped random stream
        for (int b = 0; b < MAIN_BLK; b++) send_block(b, b >= 68);
        while (out_idx < MAIN_BLK*64) @(negedge clk);

        // R6: hold the output and watch the input side close
        force_stall = 1'b1;
        accepted    = 0;
        fork
            begin
                for (int b = MAIN_BLK; b < NBLK; b++) send_block(b, 1'b0);
            end
        join_none
        repeat (3000) @(negedge clk);
        check(in_ready == 1'b0, "R6 in_ready low under stall", int'(in_ready), 0);
        check(accepted < 192, "R6 samples taken under stall", accepted, 191);
        force_stall = 1'b0;
        wait fork;
        while (out_idx < NBLK*64) @(negedge clk);
        repeat (4) @(negedge clk);
        check(out_idx == NBLK*64, "R4 output count", out_idx, NBLK*64);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule